// File: doc/BRIEF.md
# Tri-State Phase/Frequency Detector

This block compares a reference clock with a feedback clock and drives two flags, `up` and `down`. The difference between their pulse widths follows the phase error between the two inputs. The design is fully synchronous. Both inputs are brought into a fast oversampling clock domain through a synchronizer chain, and their rising edges are detected in that domain.

A rising edge on the reference sets `up`, and a rising edge on the feedback sets `down`. Once both flags are high, a reset timer waits a programmable number of oversampling cycles and then clears both flags together. Because of this deliberate overlap, both outputs still carry a pulse of known width when the inputs are in phase, so the detector has no dead zone.

The detector also acts on frequency error. Reference edges that arrive with no feedback edge in between leave `up` high for as long as they continue. An edge that arrives while the reset timer is running is held and re-sets its flag at the moment the timer clears the pair.

Top module: `phase_freq_detector`

## Requirements
- R1: After `ref_in` is first sampled high, `up` rises on the third rising clock edge, counting the sampling edge as the first.
- R2: After `fb_in` is first sampled high, `down` rises on the third rising clock edge, counting the sampling edge as the first.
- R3: Once `up` and `down` are both high, they stay high together for exactly D cycles and then fall on the same edge. D is `dly_cfg`.
- R4: When the feedback edge lags the reference edge by L cycles, the `up` pulse is L cycles wider than the `down` pulse, which is D cycles wide.
- R5: When the feedback edge leads the reference edge by L cycles, the `down` pulse is L cycles wider than the `up` pulse, which is D cycles wide.
- R6: With in-phase inputs, `up` and `down` each pulse for exactly D cycles. Neither pulse is missing.
- R7: A `dly_cfg` value of 0 behaves as a delay of one cycle.
- R8: Repeated reference edges with no feedback edge keep `up` high without a gap, and `down` stays low. Falling input edges have no effect.
- R9: A rising edge that arrives while both flags are high is held. Its flag stays or becomes high when the pair is cleared.
- R10: `rst` is synchronous and active high. It clears both flags, any held edges and the reset timer, so a later single reference edge leaves only `up` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| fb_in | input | 1 | Feedback clock, asynchronous to clk |
| dly_cfg | input | DLY_W | Overlap length in clk cycles (0 acts as 1) |
| up | output | 1 | Registered raise-frequency flag |
| down | output | 1 | Registered lower-frequency flag |

## Verification
The overlap-length assertion depends on two assumptions about the inputs. The first is that `dly_cfg` does not change while a comparison cycle is in progress. The second is that both inputs are low while `rst` is asserted, so no edge is invented when reset is released. The stimulus follows both: it writes the delay only while both flags are idle, and it holds the inputs low across every reset. Input pulses are always long enough that each rising edge is seen as a single detection pulse.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Which input a per-channel slice serves
  typedef enum logic {
    CH_REF = 1'b0,
    CH_FB  = 1'b1
  } pfd_chan_e;

  localparam int NUM_CH       = 2;
  localparam int DEF_SYNC     = 2;
  localparam int DEF_DLY_W    = 4;
endpackage

// File: rtl/pfd_edge_detect.sv
module pfd_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sig_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;

  // R1
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pfd_flag_cell.sv
module pfd_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic hold_i,
  input  logic clear_i,
  output logic flag_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      pend_q <= 1'b0;
    end else if (clear_i) begin
      flag_o <= pend_q | rise_i;
      pend_q <= 1'b0;
    end else begin
      flag_o <= flag_o | rise_i;
      pend_q <= pend_q | (rise_i & hold_i);
    end
  end

  // R1 R2
  set_follows_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rise_i |=> flag_o);

  // R9
  pend_reissue_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && clear_i) |=> flag_o);
endmodule

// File: rtl/pfd_reset_timer.sv
module pfd_reset_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             both_i,
  input  logic [DLY_W-1:0] dly_cfg,
  output logic             clear_o
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] eff_dly;

  assign eff_dly = (dly_cfg == '0) ? DLY_W'(1) : dly_cfg;
  assign clear_o = both_i && (cnt_q == eff_dly - DLY_W'(1));

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (both_i && !clear_o)
      cnt_q <= cnt_q + DLY_W'(1);
    else
      cnt_q <= '0;
  end

  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !both_i |=> (cnt_q == '0));
endmodule

// File: rtl/phase_freq_detector.sv
module phase_freq_detector #(
  parameter int SYNC_STAGES = pfd_pkg::DEF_SYNC,
  parameter int DLY_W       = pfd_pkg::DEF_DLY_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [DLY_W-1:0] dly_cfg,
  output logic             up,
  output logic             down
);
  import pfd_pkg::*;

  localparam int RUN_W = DLY_W + 1;

  logic [NUM_CH-1:0] raw_in;
  logic [NUM_CH-1:0] rise;
  logic [NUM_CH-1:0] flag;
  logic              both;
  logic              clear;

  assign raw_in[CH_REF] = ref_in;
  assign raw_in[CH_FB]  = fb_in;
  assign both           = flag[CH_REF] & flag[CH_FB];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pfd_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .sig_i  (raw_in[c]),
      .rise_o (rise[c])
    );
    pfd_flag_cell u_flag (
      .clk     (clk),
      .rst     (rst),
      .rise_i  (rise[c]),
      .hold_i  (both),
      .clear_i (clear),
      .flag_o  (flag[c])
    );
  end

  pfd_reset_timer #(.DLY_W(DLY_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .both_i  (both),
    .dly_cfg (dly_cfg),
    .clear_o (clear)
  );

  assign up   = flag[CH_REF];
  assign down = flag[CH_FB];

  // Checker state: length of the current run of both-high cycles
  logic [RUN_W-1:0] ov_run;
  logic [RUN_W-1:0] ov_min;
  assign ov_min = (dly_cfg == '0) ? RUN_W'(1) : RUN_W'(dly_cfg);

  always_ff @(posedge clk) begin
    if (rst)
      ov_run <= '0;
    else if (up && down)
      ov_run <= (ov_run == {RUN_W{1'b1}}) ? ov_run : ov_run + RUN_W'(1);
    else
      ov_run <= '0;
  end

  // R3
  up_fall_with_down_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(up) && !$past(rst)) |-> $past(down));

  // R3
  down_fall_with_up_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(down) && !$past(rst)) |-> $past(up));

  // R6
  overlap_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(up) && !$past(rst)) |-> (ov_run >= ov_min));
endmodule

// File: tb/tb_phase_freq_detector.sv
module tb_phase_freq_detector;
  localparam int DLY_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ref_in = 1'b0;
  logic             fb_in = 1'b0;
  logic [DLY_W-1:0] dly_cfg = DLY_W'(1);
  logic             up;
  logic             down;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  phase_freq_detector #(.DLY_W(DLY_W)) dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .dly_cfg(dly_cfg), .up(up), .down(down)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // lag > 0: reference first; lag < 0: feedback first
  typedef struct packed {
    int lag;
    int dly;
    int up_w;
    int dn_w;
  } row_t;

  localparam int N_ROWS = 8;
  localparam row_t ROWS [N_ROWS] = '{
    '{0, 1, 1, 1},    // R6
    '{0, 3, 3, 3},    // R6
    '{0, 0, 1, 1},    // R7
    '{2, 2, 4, 2},    // R4
    '{5, 1, 6, 1},    // R4
    '{-3, 2, 2, 5},   // R5
    '{-1, 4, 4, 5},   // R5
    '{7, 3, 10, 3}    // R4
  };

  initial begin
    int uc;
    int dc;
    int rs;
    int fs;
    int low_gap;
    bit seen;

    idle(3);
    check("R10 reset up", up, 0);
    check("R10 reset down", down, 0);
    rst = 1'b0;
    idle(3);

    // R1 / R2 latency
    dly_cfg = DLY_W'(3);
    ref_in = 1'b1;
    idle(2);
    check("R1 up not yet", up, 0);
    idle(1);
    check("R1 up set", up, 1);
    fb_in = 1'b1;
    idle(2);
    check("R2 down not yet", down, 0);
    idle(1);
    check("R2 down set", down, 1);
    ref_in = 1'b0;
    fb_in = 1'b0;
    idle(15);
    check("R3 both cleared up", up, 0);
    check("R3 both cleared down", down, 0);

    // Table walk: pulse widths against phase offset
    for (int r = 0; r < N_ROWS; r++) begin
      dly_cfg = DLY_W'(ROWS[r].dly);
      idle(6);
      rs = (ROWS[r].lag >= 0) ? 0 : -ROWS[r].lag;
      fs = (ROWS[r].lag >= 0) ? ROWS[r].lag : 0;
      uc = 0;
      dc = 0;
      for (int t = 0; t < 40; t++) begin
        ref_in = (t >= rs) && (t < rs + 20);
        fb_in  = (t >= fs) && (t < fs + 20);
        @(negedge clk);
        if (up) uc++;
        if (down) dc++;
      end
      check($sformatf("R4 R5 R6 R7 row %0d up width", r), uc, ROWS[r].up_w);
      check($sformatf("R4 R5 R6 R7 row %0d down width", r), dc, ROWS[r].dn_w);
    end

    // R8: frequency error, reference only
    dly_cfg = DLY_W'(2);
    idle(6);
    seen = 1'b0;
    low_gap = 0;
    dc = 0;
    for (int p = 0; p < 4; p++) begin
      for (int t = 0; t < 6; t++) begin
        ref_in = (t < 3);
        @(negedge clk);
        if (up) seen = 1'b1;
        if (seen && !up) low_gap++;
        if (down) dc++;
      end
    end
    idle(4);
    check("R8 up gaps", low_gap, 0);
    check("R8 down pulses", dc, 0);
    check("R8 up held", up, 1);
    fb_in = 1'b1;
    idle(12);
    fb_in = 1'b0;
    idle(6);
    check("R3 cleared after fb up", up, 0);
    check("R3 cleared after fb down", down, 0);

    // R9: reference edge arriving during the overlap is kept
    dly_cfg = DLY_W'(8);
    idle(4);
    dc = 0;
    for (int t = 0; t < 40; t++) begin
      ref_in = (t < 2) || ((t >= 4) && (t < 20));
      fb_in  = (t >= 1) && (t < 20);
      @(negedge clk);
      if (down) dc++;
    end
    check("R9 down width", dc, 8);
    check("R9 held edge sets up", up, 1);
    check("R9 down low", down, 0);

    // R10: synchronous reset wipes everything
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    check("R10 rst up", up, 0);
    check("R10 rst down", down, 0);
    idle(4);
    ref_in = 1'b1;
    idle(10);
    check("R10 single edge up", up, 1);
    check("R10 single edge down", down, 0);
    ref_in = 1'b0;
    fb_in = 1'b1;
    idle(15);
    fb_in = 1'b0;
    idle(4);
    check("R10 final up", up, 0);
    check("R10 final down", down, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule